// File: doc/BRIEF.md
# Flash Program/Erase Status Read Unit

This block sits on the read path of a parallel NOR-style flash controller. It decides what byte a host read returns while an internal program or erase runs, and during the short interval after that operation ends. While the device is busy, a read returns a status byte instead of array contents. Bit 7 is a polling flag. During a program it is the complement of the most significant bit being written. During an erase it is 0. Bit 6 inverts on every read, so host software can detect progress. Bits 5 to 0 are held at a defined fill pattern.

When busy falls, the block enters a settling window of `SETTLE_CYC` clock cycles, about 1 µs at the design clock. In that window bit 7 already shows true array data, bit 6 is frozen, and the low bits are still the fill pattern. After the window, reads return the array byte unchanged. The upstream command decoder raises busy once it has accepted the final write strobe: the 4th for a program and the 6th for an erase. Status reads are therefore meaningful from the first read after busy rises.

A read request is a level pulse on `rd_req_i`. Each rising edge counts as exactly one read. The response is a one-cycle `rd_valid_o` pulse that arrives with `rd_data_o` one clock later. There is no ready signal. Every request is accepted, and the requester must take the response in the cycle it appears, because there is no back-pressure.

Top module: `flash_status_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request seen, `rd_valid_o` is 0 and `rd_data_o` is 0x00.
- R2: A read event is a rising edge of `rd_req_i`. It is sampled at clock edge t, and `rd_valid_o` is high for exactly the cycle after edge t. A request held high for several cycles produces exactly one response.
- R3: With busy low and no settling window active, a read returns the `array_data_i` value sampled at the read event.
- R4: While busy for a program, a read returns bit 7 as the inverse of `prog_msb_i` as it was captured when busy rose.
- R5: While busy for an erase (`op_erase_i` = 1 when busy rose), a read returns bit 7 as 0.
- R6: Bit 6 is 0 on the first read after busy rises, including a read in that same cycle. It inverts on each further read while busy.
- R7: During busy and during the settling window, bits 5 to 0 of the response equal `LOW_FILL`, which defaults to all ones. Array data does not reach those bits.
- R8: `op_erase_i` and `prog_msb_i` are sampled only in the cycle busy rises. Changing them later in the same busy period does not change the responses.
- R9: The settling window covers the `SETTLE_CYC` cycles starting with the first cycle busy is sampled low. This includes a read in that very cycle. During the window, bit 7 equals `array_data_i[7]`, and bit 6 holds the value the toggle bit had reached, the same on every read.
- R10: From the `SETTLE_CYC`-th cycle after busy falls, counting the fall cycle as 0, reads return the full array byte.
- R11: A new rise of busy during the settling window ends the window and starts a fresh status period, with bit 6 restarting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_msb_i | input | 1 | Bit 7 of the byte being programmed |
| rd_req_i | input | 1 | Read request; each rising edge is one read |
| array_data_i | input | 8 | Byte read from the storage array |
| rd_valid_o | output | 1 | Response strobe, one cycle per read |
| rd_data_o | output | 8 | Response byte |

## Verification
Two things can fall in the same cycle. A read event can coincide with a change of busy, either when an operation starts or when it completes. The bench places a request edge exactly on the cycle busy rises and exactly on the cycle busy falls. It also places reads on the last settling cycle and the first cycle after it. It judges each response against a bench model, which expects the status form with bit 6 at 0 on a start read and the settling form on a completion read. Random traffic then mixes short busy periods, restarts inside the window and dense reads, to hit these coincidences many more times.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  localparam int BYTE_W = 8;
  localparam int FILL_W = 6;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  function automatic logic [BYTE_W-1:0] pack_status(
    input logic poll, input logic tog, input logic [FILL_W-1:0] fill);
    return {poll, tog, fill};
  endfunction
endpackage

// File: rtl/fs_edge_det.sv
module fs_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] prev_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_o[g] <= 1'b0;
      else        prev_o[g] <= sig_i[g];
    end
  end
endmodule

// File: rtl/fs_op_track.sv
module fs_op_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic rd_ev_i,
  input  logic op_erase_i,
  input  logic prog_msb_i,
  output logic poll_o,
  output logic tog_o
);
  logic erase_q, msb_q, tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      msb_q   <= 1'b0;
      tog_q   <= 1'b0;
    end else if (start_i) begin
      erase_q <= op_erase_i;
      msb_q   <= prog_msb_i;
      tog_q   <= rd_ev_i;
    end else if (busy_i && rd_ev_i) begin
      tog_q   <= ~tog_q;
    end
  end

  always_comb begin
    if (start_i) poll_o = op_erase_i ? 1'b0 : ~prog_msb_i;
    else         poll_o = erase_q    ? 1'b0 : ~msb_q;
    tog_o = start_i ? 1'b0 : tog_q;
  end
endmodule

// File: rtl/fs_settle_timer.sv
module fs_settle_timer #(
  parameter int SETTLE_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fall_i,
  output logic settling_o
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start_i)          cnt_q <= '0;
    else if (fall_i)           cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign settling_o = fall_i || (cnt_q != '0);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import flash_stat_pkg::*;
#(
  parameter int                SETTLE_CYC = 50,
  parameter logic [FILL_W-1:0] LOW_FILL   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              op_erase_i,
  input  logic              prog_msb_i,
  input  logic              rd_req_i,
  input  logic [BYTE_W-1:0] array_data_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [1:0]        prev;
  logic              rd_ev, start, fall, settling, poll_now, tog_now;
  phase_e            phase;
  logic [BYTE_W-1:0] resp;

  fs_edge_det #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i({rd_req_i, busy_i}), .prev_o(prev)
  );

  assign rd_ev = rd_req_i & ~prev[1];
  assign start = busy_i   & ~prev[0];
  assign fall  = ~busy_i  &  prev[0];

  fs_op_track u_track (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy_i),
    .rd_ev_i(rd_ev), .op_erase_i(op_erase_i), .prog_msb_i(prog_msb_i),
    .poll_o(poll_now), .tog_o(tog_now)
  );

  fs_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fall_i(fall),
    .settling_o(settling)
  );

  always_comb begin
    if (busy_i)        phase = PH_BUSY;
    else if (settling) phase = PH_SETTLE;
    else               phase = PH_IDLE;
  end

  always_comb begin
    unique case (phase)
      PH_BUSY:   resp = pack_status(poll_now, tog_now, LOW_FILL);
      PH_SETTLE: resp = pack_status(array_data_i[BYTE_W-1], tog_now, LOW_FILL);
      default:   resp = array_data_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_ev;
      if (rd_ev) rd_data_o <= resp;
    end
  end
endmodule

// File: rtl/fs_status_chk.sv
module fs_status_chk #(
  parameter logic [5:0] LOW_FILL = '1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       settling,
  input logic       rd_ev,
  input logic       start,
  input logic       tog_now,
  input logic [7:0] array_data_i,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |=> !rd_valid_o);

  a_r3_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !$past(busy_i) && !$past(settling)
      |-> rd_data_o == $past(array_data_i));

  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i && rd_ev) && busy_i && !start
      |-> tog_now != $past(tog_now));

  a_r7_fill_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && ($past(busy_i) || $past(settling))
      |-> rd_data_o[5:0] == LOW_FILL);
endmodule

bind flash_status_unit fs_status_chk #(.LOW_FILL(LOW_FILL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .settling(settling),
  .rd_ev(rd_ev), .start(start), .tog_now(tog_now),
  .array_data_i(array_data_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
);

// File: tb/flash_status_unit_test.sv
module flash_status_unit_test;
  localparam int SETTLE = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, op = 1'b0, pmsb = 1'b0, rd = 1'b0;
  logic [7:0] ad = 8'h00;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;

  int vectors = 0, errors = 0;

  // bench model state
  logic m_bq = 0, m_rq = 0, m_op = 0, m_b7 = 0, m_tog = 0;
  int   m_cnt = 0;
  logic exp_v = 0;
  logic [7:0] exp_d = 8'h00;
  string exp_tag = "R1";

  flash_status_unit #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(op),
    .prog_msb_i(pmsb), .rd_req_i(rd), .array_data_i(ad),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  function automatic logic [7:0] status_of(logic poll, logic tog);
    return {poll, tog, 6'h3F};
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [7:0] act, input logic [7:0] expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  // one clock: drive at negedge, model, sample at next negedge
  task automatic cyc(input logic b, input logic o, input logic p,
                     input logic r, input logic [7:0] a, input string tag);
    logic rise, st, fl, settl;
    busy = b; op = o; pmsb = p; rd = r; ad = a;
    rise  = r & ~m_rq;
    st    = b & ~m_bq;
    fl    = ~b & m_bq;
    settl = fl || (m_cnt > 0);
    exp_v = rise;
    if (rise) begin
      if (b) begin
        exp_d   = st ? status_of(o ? 1'b0 : ~p, 1'b0)
                     : status_of(m_op ? 1'b0 : ~m_b7, m_tog);
        exp_tag = st ? "R6" : (m_op ? "R5 R6 R7" : "R4 R6 R7");
      end else if (settl) begin
        exp_d   = status_of(a[7], m_tog);
        exp_tag = "R9 R7";
      end else begin
        exp_d   = a;
        exp_tag = "R3 R10";
      end
      if (tag != "") exp_tag = {tag, " ", exp_tag};
    end
    if (st) begin
      m_op = o; m_b7 = p; m_tog = rise;
    end else if (b && rise) begin
      m_tog = ~m_tog;
    end
    if (st)             m_cnt = 0;
    else if (fl)        m_cnt = SETTLE - 1;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_bq = b; m_rq = r;
    @(posedge clk);
    @(negedge clk);
    check(rd_valid_o === exp_v, "R2 valid", {7'd0, rd_valid_o}, {7'd0, exp_v});
    if (exp_v) check(rd_data_o === exp_d, exp_tag, rd_data_o, exp_d);
  endtask

  // read pulse: request high one cycle, low one cycle
  task automatic rdp(input logic b, input logic o, input logic p,
                     input logic [7:0] a, input string tag);
    cyc(b, o, p, 1'b1, a, tag);
    cyc(b, o, p, 1'b0, a, tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(rd_valid_o === 1'b0 && rd_data_o === 8'h00, "R1 reset",
          rd_data_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 8'h00, "R1");
    check(rd_valid_o === 1'b0 && rd_data_o === 8'h00, "R1 after release",
          rd_data_o, 8'h00);

    // idle reads
    rdp(0, 0, 0, 8'h5A, "R3");
    rdp(0, 0, 0, 8'hC3, "R3");
    // held request gives one response
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 8'h11, "R2 held");
    cyc(0, 0, 0, 0, 8'h11, "R2");

    // program start with read in the start cycle, msb=1 -> poll 0
    cyc(1, 0, 1, 1, 8'h00, "R6 start");
    cyc(1, 0, 1, 0, 8'h00, "");
    rdp(1, 0, 1, 8'h00, "R4");
    // op/msb change mid-busy must be ignored
    rdp(1, 1, 0, 8'h77, "R8");
    rdp(1, 1, 0, 8'h00, "R8");
    // completion with read in the fall cycle
    cyc(0, 0, 0, 1, 8'h80, "R9 fall");
    for (int k = 1; k < SETTLE - 1; k++) cyc(0, 0, 0, 0, 8'h80, "");
    cyc(0, 0, 0, 1, 8'h80, "R9 last");           // k = SETTLE-1
    cyc(0, 0, 0, 0, 8'h92, "");                  // k = SETTLE
    rdp(0, 0, 0, 8'h92, "R10 first");

    // erase, no read at start; then first read after start
    cyc(1, 1, 0, 0, 8'h00, "");
    rdp(1, 1, 0, 8'hFF, "R5");
    rdp(1, 0, 1, 8'hFF, "R5 R8");
    cyc(0, 0, 0, 0, 8'hFF, "");
    for (int k = 1; k < SETTLE; k++) cyc(0, 0, 0, 0, 8'hFF, "");
    rdp(0, 0, 0, 8'hFF, "R10 boundary");         // k = SETTLE

    // restart during settle
    rdp(1, 0, 0, 8'h00, "R4");
    cyc(0, 0, 0, 0, 8'h3C, "");
    rdp(0, 0, 0, 8'h3C, "R9");
    cyc(1, 0, 0, 1, 8'h3C, "R11 restart");
    cyc(1, 0, 0, 0, 8'h3C, "");
    rdp(1, 0, 0, 8'h3C, "R11");
    cyc(0, 0, 0, 0, 8'h3C, "");
    for (int k = 0; k < SETTLE + 2; k++) cyc(0, 0, 0, 0, 8'h3C, "");

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      logic b;
      b = busy;
      if (($urandom % 100) < (busy ? 6 : 3)) b = ~busy;
      cyc(b, 1'($urandom), 1'($urandom), 1'(($urandom % 3) == 0),
          8'($urandom), "rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule